// File: doc/BRIEF.md
# Machine Cycle Timer

This block produces the timing skeleton of every bus transaction for a small 8-bit processor. A phase counter divides time into machine cycles of a fixed number of clocks, eight by default. From the counter phase, and from a cycle kind and a 16-bit address that are captured once per cycle, the block derives two timing pulses, an address-byte select with the matching byte on a shared 8-bit address bus, and active-low memory read and write strobes.

The early pulse marks the opening of a cycle, so that external logic can latch the high address byte while it is on the bus. The late pulse marks the point where read data is valid and can be clocked into an output latch. The read strobe covers the whole of a read cycle. The write strobe is a short pulse in the back half of a write cycle, so that address and data are settled before it falls and after it rises. Instruction decoding, the datapath and the memory itself sit outside this block.

All outputs are registered. "Phase n" means the clock period that follows the n-th rising edge after the edge that opened the cycle. Phase 0 follows the opening edge.

Top module: `mct_cycle_timer`

## Requirements
- R1: Each machine cycle lasts exactly 8 clock periods. The phase runs 0 to 7 and then returns to 0, so `strobe_a` pulses exactly 8 clocks apart in steady operation.
- R2: `strobe_a` is high during phase 1 and low in every other phase.
- R3: `strobe_b` is high during phase 6 and low in every other phase.
- R4: During phases 0 and 1, `addr_hi_sel` is 1 and `addr_bus` carries bits 15:8 of the captured address. During phases 2 to 7, `addr_hi_sel` is 0 and `addr_bus` carries bits 7:0.
- R5: `mem_rd_n` is low in all eight phases of a read cycle (kind code 1) and high in every phase of any other cycle.
- R6: `mem_wr_n` is low in phases 5 and 6 of a write cycle (kind code 2) and high at all other times, including the whole of every non-write cycle.
- R7: `cyc_kind` and `addr_in` are sampled only on the rising edge that leaves phase 7 and opens the next cycle. Changes to them at any other time have no effect on the outputs of the current cycle.
- R8: While `rst` is high at a rising edge, the block enters phase 0 with `strobe_a` and `strobe_b` low, `mem_rd_n` and `mem_wr_n` high, `addr_hi_sel` 1 and `addr_bus` 0. The first cycle after reset is a no-access cycle on address 0.
- R9: Kind codes 0 and 3 are both no-access cycles: the timing pulses and the address sequence still run, and both memory strobes stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_kind | input | 2 | Kind of the next cycle: 0 none, 1 read, 2 write, 3 none |
| addr_in | input | 16 | Address for the next cycle |
| strobe_a | output | 1 | Early timing pulse, phase 1 |
| strobe_b | output | 1 | Late timing pulse, phase 6 |
| addr_hi_sel | output | 1 | 1 while the high address byte is on the bus |
| addr_bus | output | 8 | Multiplexed address byte |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |

## Verification
The bench builds the block with its default parameters: eight phases, a 16-bit address and an 8-bit bus. With these values every phase position is reached within a few hundred clocks, including the wrap from phase 7 to phase 0, the write window at phases 5 and 6, and both address-byte halves. Directed cycles of each of the four kind codes are followed by a long stretch in which the inputs change on every clock, so the requirement that inputs are captured only at cycle start is tested in every phase. A reset pulse placed in the middle of a cycle tests the return to phase 0 and the no-access cycle that follows it.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_RSVD  = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic strobe_a;
        logic strobe_b;
        logic hi_sel;
        logic rd_n;
        logic wr_n;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '{
        strobe_a: 1'b0,
        strobe_b: 1'b0,
        hi_sel:   1'b1,
        rd_n:     1'b1,
        wr_n:     1'b1
    };

endpackage

// File: rtl/mct_phase_ctr.sv
module mct_phase_ctr #(
    parameter int PHASES = 8,
    parameter int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_q,
    output logic [PW-1:0] phase_d,
    output logic          last
);
    localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

    always_comb begin
        last = (phase_q == LAST_PH);
        if (rst || last) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    // R1: the counter steps by one and wraps only after the last phase
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (phase_q != LAST_PH) |=> (phase_q == $past(phase_q) + PW'(1)));
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST_PH) |=> (phase_q == '0));

endmodule

// File: rtl/mct_strobe_dec.sv
module mct_strobe_dec
    import mct_pkg::*;
#(
    parameter int PW       = 3,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int HI_LAST  = 1,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6
) (
    input  logic [PW-1:0] phase,
    input  cyc_kind_e     kind,
    output strobes_t      strb
);
    localparam logic [PW-1:0] PH_A  = PW'(TPA_PH);
    localparam logic [PW-1:0] PH_B  = PW'(TPB_PH);
    localparam logic [PW-1:0] PH_HI = PW'(HI_LAST);
    localparam logic [PW-1:0] PH_W0 = PW'(WR_FIRST);
    localparam logic [PW-1:0] PH_W1 = PW'(WR_LAST);

    logic is_rd;
    logic is_wr;
    logic in_wr_win;

    always_comb begin
        is_rd         = (kind == CYC_READ);
        is_wr         = (kind == CYC_WRITE);
        in_wr_win     = (phase >= PH_W0) && (phase <= PH_W1);
        strb.strobe_a = (phase == PH_A);
        strb.strobe_b = (phase == PH_B);
        strb.hi_sel   = (phase <= PH_HI);
        strb.rd_n     = !is_rd;
        strb.wr_n     = !(is_wr && in_wr_win);
    end

endmodule

// File: rtl/mct_cycle_timer.sv
module mct_cycle_timer
    import mct_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BUS_W    = 8,
    parameter int PHASES   = 8,
    parameter int TPA_PH   = 1,
    parameter int TPB_PH   = 6,
    parameter int HI_LAST  = 1,
    parameter int WR_FIRST = 5,
    parameter int WR_LAST  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cyc_kind,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              strobe_a,
    output logic              strobe_b,
    output logic              addr_hi_sel,
    output logic [BUS_W-1:0]  addr_bus,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);
    localparam int PW = $clog2(PHASES);

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } ctx_t;

    typedef struct packed {
        strobes_t         strb;
        logic [BUS_W-1:0] bus;
    } out_t;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_d;
    logic          last;
    ctx_t          ctx_d, ctx_q;
    out_t          out_d, out_q;
    strobes_t      dec_strb;

    mct_phase_ctr #(
        .PHASES (PHASES),
        .PW     (PW)
    ) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .last    (last)
    );

    always_comb begin
        ctx_d = ctx_q;
        if (rst) begin
            ctx_d.kind = CYC_IDLE;
            ctx_d.addr = '0;
        end else if (last) begin
            ctx_d.kind = cyc_kind_e'(cyc_kind);
            ctx_d.addr = addr_in;
        end
    end

    mct_strobe_dec #(
        .PW       (PW),
        .TPA_PH   (TPA_PH),
        .TPB_PH   (TPB_PH),
        .HI_LAST  (HI_LAST),
        .WR_FIRST (WR_FIRST),
        .WR_LAST  (WR_LAST)
    ) dec_i (
        .phase (phase_d),
        .kind  (ctx_d.kind),
        .strb  (dec_strb)
    );

    always_comb begin
        if (rst) begin
            out_d.strb = STROBES_IDLE;
            out_d.bus  = '0;
        end else begin
            out_d.strb = dec_strb;
            out_d.bus  = dec_strb.hi_sel ? ctx_d.addr[ADDR_W-1 -: BUS_W]
                                         : ctx_d.addr[BUS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        ctx_q <= ctx_d;
        out_q <= out_d;
    end

    assign strobe_a    = out_q.strb.strobe_a;
    assign strobe_b    = out_q.strb.strobe_b;
    assign addr_hi_sel = out_q.strb.hi_sel;
    assign mem_rd_n    = out_q.strb.rd_n;
    assign mem_wr_n    = out_q.strb.wr_n;
    assign addr_bus    = out_q.bus;

    // R2: the early pulse lasts a single clock
    a_r2_tpa_single: assert property (@(posedge clk) disable iff (rst)
        strobe_a |=> !strobe_a);
    // R2: the early pulse appears only in phase 1 of the counter
    a_r2_tpa_phase: assert property (@(posedge clk) disable iff (rst)
        strobe_a |-> (phase_q == PW'(TPA_PH)));
    // R3: the late pulse never overlaps the early one
    a_r3_tpb_apart: assert property (@(posedge clk) disable iff (rst)
        strobe_b |-> !strobe_a);
    // R4: the low byte stays put while it is on the bus
    a_r4_low_hold: assert property (@(posedge clk) disable iff (rst)
        (!addr_hi_sel && $past(!addr_hi_sel)) |-> $stable(addr_bus));
    // R5 R7: the read strobe changes only at a cycle boundary
    a_r5_rd_steady: assert property (@(posedge clk) disable iff (rst)
        (phase_q != '0) |-> $stable(mem_rd_n));
    // R6: a write pulse never coincides with a read
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> mem_rd_n);

endmodule

// File: tb/mct_cycle_timer_tb_top.sv
`timescale 1ns/100ps
module mct_cycle_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cyc_kind = 2'd0;
    logic [15:0] addr_in = 16'h0000;
    logic        strobe_a, strobe_b, addr_hi_sel, mem_rd_n, mem_wr_n;
    logic [7:0]  addr_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mct_cycle_timer dut_i (
        .clk         (clk),
        .rst         (rst),
        .cyc_kind    (cyc_kind),
        .addr_in     (addr_in),
        .strobe_a    (strobe_a),
        .strobe_b    (strobe_b),
        .addr_hi_sel (addr_hi_sel),
        .addr_bus    (addr_bus),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n)
    );

    // reference model state, advanced at every rising edge
    int          m_ph = 0;
    int          m_kind = 0;
    logic [15:0] m_addr = 16'h0000;
    bit          m_rst = 1'b1;
    bit          seen_edge = 1'b0;
    int          cyc_no = 0;
    int          last_tpa = -1;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        m_rst     <= rst;
        if (rst) begin
            m_ph   <= 0;
            m_kind <= 0;
            m_addr <= 16'h0000;
        end else if (m_ph == 7) begin
            m_ph   <= 0;
            m_kind <= int'(cyc_kind);
            m_addr <= addr_in;
        end else begin
            m_ph <= m_ph + 1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at clock %0d: got %0h expected %0h", tag, cyc_no, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge && !finished) begin
            cyc_no++;
            if (m_rst) begin
                chk("R8 reset outputs",
                    {strobe_a, strobe_b, addr_hi_sel, mem_rd_n, mem_wr_n, addr_bus},
                    {5'b00111, 8'h00});
                last_tpa = -1;
            end else begin
                chk("R2 strobe_a", strobe_a, m_ph == 1);
                chk("R3 strobe_b", strobe_b, m_ph == 6);
                chk("R4 addr_hi_sel", addr_hi_sel, m_ph < 2);
                chk("R4 R7 addr_bus", addr_bus, (m_ph < 2) ? m_addr[15:8] : m_addr[7:0]);
                chk("R5 R9 mem_rd_n", mem_rd_n, m_kind != 1);
                chk("R6 R9 mem_wr_n", mem_wr_n, !(m_kind == 2 && (m_ph == 5 || m_ph == 6)));
                if (strobe_a) begin
                    if (last_tpa >= 0) chk("R1 cycle length", cyc_no - last_tpa, 8);
                    last_tpa = cyc_no;
                end
            end
        end
    end

    task automatic hold_cycle(input logic [1:0] k, input logic [15:0] a);
        cyc_kind = k;
        addr_in  = a;
        repeat (8) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic churn(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            cyc_kind = 2'($urandom_range(0, 3));
            addr_in  = 16'($urandom);
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R8: first cycle after reset runs as no access on address 0
        repeat (7) begin
            @(posedge clk);
            #1;
        end
        // directed cycles of every kind code (R5 R6 R9)
        hold_cycle(2'd1, 16'hA55A);
        hold_cycle(2'd2, 16'h3CC3);
        hold_cycle(2'd0, 16'hFF01);
        hold_cycle(2'd3, 16'h1234);
        hold_cycle(2'd2, 16'h8001);
        hold_cycle(2'd2, 16'h7FFE);
        hold_cycle(2'd1, 16'h0000);
        // inputs changing every clock (R7)
        churn(300);
        // reset in mid cycle (R8)
        repeat (3) begin
            @(posedge clk);
            #1;
        end
        rst = 1'b1;
        cyc_kind = 2'd1;
        addr_in = 16'hBEEF;
        repeat (2) begin
            @(posedge clk);
            #1;
        end
        rst = 1'b0;
        churn(160);
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            finish_run();
        end
    end

endmodule